// File: doc/BRIEF.md
# Carry-Save Radix-2 Montgomery Multiplier

This block forms the Montgomery product Z = X·Y·2^(-n) mod M of two n-bit operands for an odd modulus M, with X and Y already reduced below M. One bit of X is used per clock cycle, starting with its least significant bit. The running partial sum is kept as two vectors, a sum and a carry. Each cycle the previous sum, the previous carry, the multiplicand gated by the current bit of X and the modulus gated by a parity bit are merged by a 4-to-2 carry-save stage. No carry travels across the word inside the loop.

The parity bit is taken from the low bits of the two vectors and of the gated multiplicand. It chooses whether M is added so that the total becomes even. The two vectors are then shifted right by one place. After n cycles one carry-propagate addition joins the vectors. A single conditional subtraction of M then brings the value into [0, M).

A caller drives the operands and pulses start. It waits for the one-cycle done pulse and reads the result, which stays valid until the next completion. Conversion into and out of the Montgomery domain is done outside the block.

Top module: `csa_mont_mul`

## Requirements
- R1: While rst_ni is low and after release with no start, done_o is 0 and result_o is 0.
- R2: For odd M and X, Y < M, the result_o presented with done_o equals the unique Z in [0, M) with Z·2^N_BITS ≡ X·Y (mod M).
- R3: done_o is high for exactly one cycle, at the (N_BITS+1)-th rising edge after the edge that samples start_i high in the idle state.
- R4: A start_i pulse while a computation is in progress has no effect: the running result and the done timing belong to the operands of the accepted start.
- R5: result_o holds its value from one done_o pulse until the next.
- R6: x_i, y_i and m_i are sampled only at the accepted start; changing them during the computation does not change the result.
- R7: If X or Y is zero, the result is zero. If M is 1, the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication when idle |
| x_i | input | N_BITS | Multiplier operand, read bit-serially from the LSB |
| y_i | input | N_BITS | Multiplicand operand |
| m_i | input | N_BITS | Odd modulus |
| result_o | output | N_BITS | Montgomery product, less than M |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses operands equal to M-1, the largest odd modulus, M of 1 and 3, and zero operands. With M-1 operands the combined vectors come closest to 2M, so a missing final subtraction or a truncated vector gives a result of M or more, or a wrapped one. A parity bit that ignores the carry vector's LSB sums an odd value and loses a bit at every shift, which gives wrong products on random operands. A second start sent mid-run and operand inputs changed during the run would, in a design that reloads or reads the inputs live, give the product of the wrong operands or move the done pulse away from its fixed cycle.

// File: rtl/csa_mont_pkg.sv
package csa_mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mm_state_e;
endpackage

// File: rtl/csa_3to2.sv
module csa_3to2 #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] co_o
);
  logic [W-1:0] maj;
  assign s_o  = a_i ^ b_i ^ c_i;
  assign maj  = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign co_o = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/csa_4to2.sv
module csa_4to2 #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] co_o
);
  logic [W-1:0] s1, c1;

  csa_3to2 #(.W(W)) u_lvl0 (.a_i(a_i), .b_i(b_i), .c_i(c_i), .s_o(s1), .co_o(c1));
  csa_3to2 #(.W(W)) u_lvl1 (.a_i(s1), .b_i(c1), .c_i(d_i), .s_o(s_o), .co_o(co_o));
endmodule

// File: rtl/mont_final.sv
module mont_final #(
  parameter int unsigned NB = 16
) (
  input  logic [NB+1:0] s_i,
  input  logic [NB+1:0] c_i,
  input  logic [NB-1:0] m_i,
  output logic [NB-1:0] res_o
);
  logic [NB+1:0] sum, diff;

  // single carry-propagate add, then one conditional subtract (sum < 2M)
  assign sum   = s_i + c_i;
  assign diff  = sum - {2'b00, m_i};
  assign res_o = (sum >= {2'b00, m_i}) ? diff[NB-1:0] : sum[NB-1:0];
endmodule

// File: rtl/csa_mont_mul.sv
module csa_mont_mul
  import csa_mont_pkg::*;
#(
  parameter int unsigned N_BITS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_BITS-1:0] x_i,
  input  logic [N_BITS-1:0] y_i,
  input  logic [N_BITS-1:0] m_i,
  output logic [N_BITS-1:0] result_o,
  output logic              done_o
);
  localparam int unsigned VW = N_BITS + 2;
  localparam int unsigned AW = N_BITS + 3;
  localparam int unsigned CW = $clog2(N_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(N_BITS - 1);

  mm_state_e         state_q;
  logic [N_BITS-1:0] x_q, y_q, m_q, res_q, fin_res;
  logic [VW-1:0]     s_q, c_q;
  logic [CW-1:0]     cnt_q;
  logic              done_q;

  logic [N_BITS-1:0] xy_term, qm_term;
  logic              q_bit;
  logic [AW-1:0]     sn, cn;

  assign xy_term = x_q[0] ? y_q : '0;
  // parity of S + x_i*Y from the low bits only
  assign q_bit   = s_q[0] ^ c_q[0] ^ xy_term[0];
  assign qm_term = q_bit ? m_q : '0;

  csa_4to2 #(.W(AW)) u_csa (
    .a_i ({1'b0, s_q}),
    .b_i ({1'b0, c_q}),
    .c_i ({3'b000, xy_term}),
    .d_i ({3'b000, qm_term}),
    .s_o (sn),
    .co_o(cn)
  );

  mont_final #(.NB(N_BITS)) u_fin (
    .s_i  (s_q),
    .c_i  (c_q),
    .m_i  (m_q),
    .res_o(fin_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      m_q     <= '0;
      s_q     <= '0;
      c_q     <= '0;
      cnt_q   <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          x_q     <= x_i;
          y_q     <= y_i;
          m_q     <= m_i;
          s_q     <= '0;
          c_q     <= '0;
          cnt_q   <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          // both vectors have an even LSB here, so the shift is exact
          s_q   <= sn[AW-1:1];
          c_q   <= cn[AW-1:1];
          x_q   <= x_q >> 1;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN: begin
          res_q   <= fin_res;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/csa_mont_mul_chk.sv
module csa_mont_mul_chk
  import csa_mont_pkg::*;
#(
  parameter int unsigned N_BITS = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          start_i,
  input logic                          done_o,
  input logic [N_BITS-1:0]             result_o,
  input logic [N_BITS-1:0]             m_q,
  input mm_state_e                     state_q,
  input logic [$clog2(N_BITS+1)-1:0]   cnt_q
);
  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  done_after_fin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q) == ST_FIN);

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q < N_BITS));

  // R2
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o < m_q));

  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R4
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(m_q));
endmodule

bind csa_mont_mul csa_mont_mul_chk #(.N_BITS(N_BITS)) chk_i (.*);

// File: tb/csa_mont_mul_tb_top.sv
module csa_mont_mul_tb_top;
  localparam int unsigned NB = 16;
  localparam time CLK_PERIOD = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [NB-1:0] x_i = '0, y_i = '0, m_i = '0;
  logic [NB-1:0] result_o;
  logic          done_o;

  int checks = 0;
  int fails  = 0;

  csa_mont_mul #(.N_BITS(NB)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .x_i(x_i), .y_i(y_i), .m_i(m_i),
    .result_o(result_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [NB-1:0] ref_mont(logic [NB-1:0] x, logic [NB-1:0] y, logic [NB-1:0] m);
    logic [63:0] a;
    a = (64'(x) * 64'(y)) % 64'(m);
    for (int i = 0; i < NB; i++) begin
      if (a[0]) a = a + 64'(m);
      a = a >> 1;
    end
    return a[NB-1:0];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // disturb: send a second start and new operands mid-run (R4, R6)
  task automatic run(logic [NB-1:0] x, logic [NB-1:0] y, logic [NB-1:0] m, bit disturb, string req);
    int cyc;
    @(negedge clk_i);
    x_i = x; y_i = y; m_i = m; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 1;
    if (disturb) begin
      x_i = ~x; y_i = y ^ 16'h5a5a; m_i = m ^ 16'h0f0e;
    end
    while (!done_o && cyc < 1000) begin
      if (disturb && cyc == 5) start_i = 1'b1;
      if (disturb && cyc == 6) start_i = 1'b0;
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    // capture edge, then N_BITS+1 edges: done seen at negedge count NB+2
    check({req, " R3 latency"}, 64'(cyc), 64'(NB + 2));
    check(req, 64'(result_o), 64'(ref_mont(x, y, m)));
    @(negedge clk_i);
    check("R3 pulse width", 64'(done_o), 64'd0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [NB-1:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R1 done in reset", 64'(done_o), 64'd0);
    check("R1 result in reset", 64'(result_o), 64'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 done idle", 64'(done_o), 64'd0);
    check("R1 result idle", 64'(result_o), 64'd0);

    run(16'd2, 16'd2, 16'd3, 1'b0, "R2 small");
    run(16'hfffe, 16'hfffe, 16'hffff, 1'b0, "R2 max operands");
    run(16'd0, 16'h1234, 16'h8001, 1'b0, "R7 x zero");
    run(16'h4321, 16'd0, 16'h8001, 1'b0, "R7 y zero");
    run(16'd0, 16'd0, 16'd1, 1'b0, "R7 m one");
    run(16'h1, 16'h1, 16'hc001, 1'b0, "R2 unit");
    run(16'hc000, 16'hc000, 16'hc001, 1'b0, "R2 near m");

    run(16'h7777, 16'h1357, 16'hf00d, 1'b1, "R4 R6 disturbed");
    held = result_o;
    repeat (7) @(negedge clk_i);
    check("R5 result hold", 64'(result_o), 64'(held));

    for (int k = 0; k < 200; k++) begin
      logic [NB-1:0] m, x, y;
      m = NB'($urandom) | 16'h0001;
      if (m == 16'd1) m = 16'd3;
      x = NB'($urandom % m);
      y = NB'($urandom % m);
      run(x, y, m, (k % 17) == 3, "R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule